// File: doc/BRIEF.md
# Drag-and-Drop Pipeline Arranger

This controller runs in the display clock domain and turns mouse gestures into a configuration for an image-processing pipeline. Six movable tiles sit on screen. Tiles 0 and 1 are the two preprocessing filters: smoothing first, then median. Tiles 2 to 5 are morphology steps, and each of these can act as an erode or a dilate. The user picks a tile up with a button press, carries it with the cursor and lets it go. When a tile is dropped with its centre inside the zone for its kind, it snaps into a centred row in that zone. When it is dropped anywhere else, it returns to its fixed home position.

The left-to-right order of the tiles placed in a zone is also the processing order. The block reports that order as packed slot vectors, so downstream filter and morphology stages can be steered without per-tile bookkeeping. A scroll pulse over an idle morphology tile flips that tile between erode and dilate. A drop is recognised only after the button has stayed low for a long run of consecutive cycles, so a bouncing button cannot end a drag by accident.

Top module: `tile_arranger`

## Requirements
- R1: After reset, every tile i sits at its home position x = HOME_X0 + i·HOME_STEP, y = HOME_Y. No tile is placed, every morphology tile is in erode mode (flag 0), every slot code reads 7 (empty) and slot_dilate is 0.
- R2: While no drag is active, a press edge with the cursor inside a tile's rectangle starts dragging that tile and clears its placed flag at once. A press edge with no tile under the cursor changes nothing.
- R3: While a tile is dragged, its top-left position is the cursor minus (TILE_W/2, TILE_H/2), clamped to [0, SCR_W−TILE_W] × [0, SCR_H−TILE_H]. It follows the cursor one cycle later.
- R4: A drag ends only after btn_level has been sampled low on REL_TH consecutive cycles. A shorter low run followed by high leaves the drag active.
- R5: On a drop, the tile's centre (top-left + half size) is tested against the zone of its own kind, with the left and top edges inclusive and the right and bottom edges exclusive. If the centre is inside, the tile becomes placed. Otherwise it returns home unplaced, and this includes a drop into the zone of the other kind.
- R6: With N placed preprocessing tiles, the tile of rank r sits at x = PRE_X + (PRE_W − N·TILE_W − (N−1)·PRE_GAP)/2 + r·(TILE_W+PRE_GAP) and y = PRE_Y + (PRE_H−TILE_H)/2.
- R7: With N placed morphology tiles, the tile of rank r sits at x = MOR_X + (MOR_W − N·TILE_W)/2 + r·TILE_W and y = MOR_Y + (MOR_H−TILE_H)/2. A tile's rank counts the other placed tiles of its zone whose x is smaller, or equal with a lower index.
- R8: When no drag is active, a scroll_up or scroll_down pulse with the cursor over a morphology tile toggles that tile's mode. The pulse has no effect over a preprocessing tile or while a drag is active.
- R9: slot_order bits [3k+2:3k] hold the index of the morphology tile of rank k, or 7 when slot k is empty. pre_order does the same for the two preprocessing slots.
- R10: morph_dilate bit k is the mode of tile k+2 (1 = dilate). slot_dilate bit k is the mode of the tile in morphology slot k, and 0 for an empty slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_x | input | 10 | Cursor column |
| cur_y | input | 10 | Cursor row |
| btn_level | input | 1 | Debounced left-button level |
| btn_press | input | 1 | One-cycle pulse on a button press |
| scroll_up | input | 1 | One-cycle scroll-up pulse |
| scroll_down | input | 1 | One-cycle scroll-down pulse |
| tile_x | output | 60 | Tile top-left x, tile i in bits [10i+9:10i] |
| tile_y | output | 60 | Tile top-left y, tile i in bits [10i+9:10i] |
| tile_placed | output | 6 | Placed flag per tile |
| morph_dilate | output | 4 | Mode of morphology tiles 2..5 |
| slot_dilate | output | 4 | Mode per morphology slot |
| slot_order | output | 12 | Tile index per morphology slot |
| pre_order | output | 6 | Tile index per preprocessing slot |

## Verification
The assertions assume that the inputs behave like the output of a mouse front end. btn_press pulses only in a cycle where btn_level is high. Scroll pulses last one cycle. The cursor stays within the screen. The release window is at least one cycle long. The stimulus follows these rules. It picks tiles up only at the centre of their expected position, so no two tiles overlap under the cursor, and it drives every input on the falling clock edge. Random drops aim at the matching zone, at the opposite zone or anywhere on screen. Directed cases cover the screen edges, a release that ends too early and scroll pulses that must be ignored.

// File: rtl/tile_arr_pkg.sv
package tile_arr_pkg;
  localparam int COORD_W   = 10;
  localparam int NUM_TILES = 6;
  localparam int NUM_PRE   = 2;
  localparam int NUM_MOR   = NUM_TILES - NUM_PRE;
  localparam int IDX_W     = 3;
  localparam logic [IDX_W-1:0] SLOT_EMPTY = '1;
  typedef logic [COORD_W-1:0] coord_t;
endpackage

// File: rtl/arr_release_filter.sv
// Counts consecutive low samples of the button while a drag is armed and
// fires once the run reaches HOLD_CYC samples.
module arr_release_filter #(
  parameter int HOLD_CYC = 2_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic btn_level,
  output logic fire
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !armed || btn_level) run_q <= '0;
    else if (run_q != LAST)         run_q <= run_q + 1'b1;
  end

  assign fire = armed && !btn_level && (run_q == LAST);
endmodule

// File: rtl/arr_tile_hit.sv
// Cursor hit test against every tile rectangle; lowest index has priority.
module arr_tile_hit
  import tile_arr_pkg::*;
#(
  parameter int N = NUM_TILES,
  parameter int W = 64,
  parameter int H = 32
) (
  input  coord_t                   cur_x,
  input  coord_t                   cur_y,
  input  logic [N-1:0][COORD_W-1:0] pos_x,
  input  logic [N-1:0][COORD_W-1:0] pos_y,
  output logic [N-1:0]             hov,
  output logic                     any_hit,
  output logic [IDX_W-1:0]         first_hit
);
  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hov[i] = (int'(cur_x) >= int'(pos_x[i])) && (int'(cur_x) < int'(pos_x[i]) + W) &&
                    (int'(cur_y) >= int'(pos_y[i])) && (int'(cur_y) < int'(pos_y[i]) + H);
  end

  assign any_hit = |hov;

  always_comb begin
    first_hit = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hov[i]) first_hit = IDX_W'(i);
    end
  end
endmodule

// File: rtl/arr_zone_layout.sv
// Ranks the placed tiles of one zone by x and computes their snapped slots.
module arr_zone_layout
  import tile_arr_pkg::*;
#(
  parameter int M   = 4,
  parameter int ZX  = 280,
  parameter int ZY  = 120,
  parameter int ZW  = 320,
  parameter int ZH  = 60,
  parameter int W   = 64,
  parameter int H   = 32,
  parameter int GAP = 0,
  localparam int RW = (M > 1) ? $clog2(M) : 1
) (
  input  logic [M-1:0]              placed,
  input  logic [M-1:0][COORD_W-1:0] px,
  output logic [M-1:0][COORD_W-1:0] snap_x,
  output coord_t                    snap_y,
  output logic [M-1:0]              slot_used,
  output logic [M-1:0][RW-1:0]      slot_loc
);
  int rk_v [M];
  int cnt_v;
  int margin_v;

  always_comb begin
    cnt_v = 0;
    for (int i = 0; i < M; i++) cnt_v += int'(placed[i]);
    margin_v = (cnt_v > 0) ? (ZW - cnt_v * W - (cnt_v - 1) * GAP) / 2 : 0;
    for (int i = 0; i < M; i++) begin
      rk_v[i] = 0;
      for (int j = 0; j < M; j++) begin
        if (j != i && placed[j] && ((px[j] < px[i]) || (px[j] == px[i] && j < i)))
          rk_v[i] += 1;
      end
      snap_x[i] = COORD_W'(ZX + margin_v + rk_v[i] * (W + GAP));
    end
  end

  always_comb begin
    for (int k = 0; k < M; k++) begin
      slot_used[k] = 1'b0;
      slot_loc[k]  = '0;
      for (int i = 0; i < M; i++) begin
        if (placed[i] && rk_v[i] == k) begin
          slot_used[k] = 1'b1;
          slot_loc[k]  = RW'(i);
        end
      end
    end
  end

  assign snap_y = COORD_W'(ZY + (ZH - H) / 2);
endmodule

// File: rtl/tile_arranger.sv
module tile_arranger
  import tile_arr_pkg::*;
#(
  parameter int SCR_W     = 640,
  parameter int SCR_H     = 480,
  parameter int TILE_W    = 64,
  parameter int TILE_H    = 32,
  parameter int REL_TH    = 2_000_000,
  parameter int PRE_X     = 40,
  parameter int PRE_Y     = 120,
  parameter int PRE_W     = 200,
  parameter int PRE_H     = 60,
  parameter int PRE_GAP   = 16,
  parameter int MOR_X     = 280,
  parameter int MOR_Y     = 120,
  parameter int MOR_W     = 320,
  parameter int MOR_H     = 60,
  parameter int HOME_X0   = 40,
  parameter int HOME_STEP = 80,
  parameter int HOME_Y    = 300
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [COORD_W-1:0]           cur_x,
  input  logic [COORD_W-1:0]           cur_y,
  input  logic                         btn_level,
  input  logic                         btn_press,
  input  logic                         scroll_up,
  input  logic                         scroll_down,
  output logic [NUM_TILES*COORD_W-1:0] tile_x,
  output logic [NUM_TILES*COORD_W-1:0] tile_y,
  output logic [NUM_TILES-1:0]         tile_placed,
  output logic [NUM_MOR-1:0]           morph_dilate,
  output logic [NUM_MOR-1:0]           slot_dilate,
  output logic [NUM_MOR*IDX_W-1:0]     slot_order,
  output logic [NUM_PRE*IDX_W-1:0]     pre_order
);
  localparam int HALF_W = TILE_W / 2;
  localparam int HALF_H = TILE_H / 2;
  localparam int MAX_X  = SCR_W - TILE_W;
  localparam int MAX_Y  = SCR_H - TILE_H;
  localparam int PRE_RW = (NUM_PRE > 1) ? $clog2(NUM_PRE) : 1;
  localparam int MOR_RW = (NUM_MOR > 1) ? $clog2(NUM_MOR) : 1;

  function automatic coord_t home_x(int i);
    return COORD_W'(HOME_X0 + i * HOME_STEP);
  endfunction

  // tile state
  logic [NUM_TILES-1:0][COORD_W-1:0] pos_x, pos_y;
  logic [NUM_TILES-1:0]              placed;
  logic [NUM_MOR-1:0]                dil;
  logic                              drag_on;
  logic [IDX_W-1:0]                  drag_sel;

  // hit test
  logic [NUM_TILES-1:0] hov;
  logic                 any_hit;
  logic [IDX_W-1:0]     first_hit;

  arr_tile_hit #(.N(NUM_TILES), .W(TILE_W), .H(TILE_H)) u_hit (
    .cur_x     (cur_x),
    .cur_y     (cur_y),
    .pos_x     (pos_x),
    .pos_y     (pos_y),
    .hov       (hov),
    .any_hit   (any_hit),
    .first_hit (first_hit)
  );

  // release filter
  logic drop_now;

  arr_release_filter #(.HOLD_CYC(REL_TH)) u_rel (
    .clk       (clk),
    .rst       (rst),
    .armed     (drag_on),
    .btn_level (btn_level),
    .fire      (drop_now)
  );

  // zone layouts
  logic [NUM_PRE-1:0][COORD_W-1:0] pre_sx;
  coord_t                          pre_sy;
  logic [NUM_PRE-1:0]              pre_used;
  logic [NUM_PRE-1:0][PRE_RW-1:0]  pre_loc;
  logic [NUM_MOR-1:0][COORD_W-1:0] mor_sx;
  coord_t                          mor_sy;
  logic [NUM_MOR-1:0]              mor_used;
  logic [NUM_MOR-1:0][MOR_RW-1:0]  mor_loc;

  arr_zone_layout #(
    .M(NUM_PRE), .ZX(PRE_X), .ZY(PRE_Y), .ZW(PRE_W), .ZH(PRE_H),
    .W(TILE_W), .H(TILE_H), .GAP(PRE_GAP)
  ) u_pre_lay (
    .placed    (placed[NUM_PRE-1:0]),
    .px        (pos_x[NUM_PRE-1:0]),
    .snap_x    (pre_sx),
    .snap_y    (pre_sy),
    .slot_used (pre_used),
    .slot_loc  (pre_loc)
  );

  arr_zone_layout #(
    .M(NUM_MOR), .ZX(MOR_X), .ZY(MOR_Y), .ZW(MOR_W), .ZH(MOR_H),
    .W(TILE_W), .H(TILE_H), .GAP(0)
  ) u_mor_lay (
    .placed    (placed[NUM_TILES-1:NUM_PRE]),
    .px        (pos_x[NUM_TILES-1:NUM_PRE]),
    .snap_x    (mor_sx),
    .snap_y    (mor_sy),
    .slot_used (mor_used),
    .slot_loc  (mor_loc)
  );

  // drag target with clamping
  coord_t drag_x, drag_y;
  int     tx_v, ty_v;

  always_comb begin
    tx_v = int'(cur_x) - HALF_W;
    ty_v = int'(cur_y) - HALF_H;
    if (tx_v < 0)     tx_v = 0;
    if (tx_v > MAX_X) tx_v = MAX_X;
    if (ty_v < 0)     ty_v = 0;
    if (ty_v > MAX_Y) ty_v = MAX_Y;
    drag_x = COORD_W'(tx_v);
    drag_y = COORD_W'(ty_v);
  end

  // drop validity: centre of dragged tile inside the zone of its kind
  int   ctr_x, ctr_y;
  logic in_pre, in_mor, drop_ok;

  always_comb begin
    ctr_x   = int'(pos_x[drag_sel]) + HALF_W;
    ctr_y   = int'(pos_y[drag_sel]) + HALF_H;
    in_pre  = (ctr_x >= PRE_X) && (ctr_x < PRE_X + PRE_W) &&
              (ctr_y >= PRE_Y) && (ctr_y < PRE_Y + PRE_H);
    in_mor  = (ctr_x >= MOR_X) && (ctr_x < MOR_X + MOR_W) &&
              (ctr_y >= MOR_Y) && (ctr_y < MOR_Y + MOR_H);
    drop_ok = (drag_sel < IDX_W'(NUM_PRE)) ? in_pre : in_mor;
  end

  logic scroll_any;
  assign scroll_any = scroll_up || scroll_down;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_TILES; i++) begin
        pos_x[i] <= home_x(i);
        pos_y[i] <= COORD_W'(HOME_Y);
      end
      placed      <= '0;
      dil         <= '0;
      drag_on     <= 1'b0;
      drag_sel    <= '0;
      slot_dilate <= '0;
      slot_order  <= {NUM_MOR{SLOT_EMPTY}};
      pre_order   <= {NUM_PRE{SLOT_EMPTY}};
    end else begin
      // placed tiles track their snapped slot
      for (int i = 0; i < NUM_PRE; i++) begin
        if (placed[i]) begin
          pos_x[i] <= pre_sx[i];
          pos_y[i] <= pre_sy;
        end
      end
      for (int k = 0; k < NUM_MOR; k++) begin
        if (placed[NUM_PRE+k]) begin
          pos_x[NUM_PRE+k] <= mor_sx[k];
          pos_y[NUM_PRE+k] <= mor_sy;
        end
      end

      if (!drag_on) begin
        if (btn_press && any_hit) begin
          drag_on          <= 1'b1;
          drag_sel         <= first_hit;
          placed[first_hit] <= 1'b0;
        end else if (scroll_any && any_hit && first_hit >= IDX_W'(NUM_PRE)) begin
          for (int k = 0; k < NUM_MOR; k++) begin
            if (first_hit == IDX_W'(NUM_PRE + k)) dil[k] <= ~dil[k];
          end
        end
      end else if (drop_now) begin
        drag_on <= 1'b0;
        if (drop_ok) begin
          placed[drag_sel] <= 1'b1;
        end else begin
          pos_x[drag_sel] <= home_x(int'(drag_sel));
          pos_y[drag_sel] <= COORD_W'(HOME_Y);
        end
      end else begin
        pos_x[drag_sel] <= drag_x;
        pos_y[drag_sel] <= drag_y;
      end

      // packed slot vectors for downstream stages
      for (int k = 0; k < NUM_MOR; k++) begin
        slot_order[k*IDX_W +: IDX_W] <= mor_used[k] ?
            IDX_W'(NUM_PRE) + IDX_W'(mor_loc[k]) : SLOT_EMPTY;
        slot_dilate[k] <= mor_used[k] && dil[mor_loc[k]];
      end
      for (int k = 0; k < NUM_PRE; k++) begin
        pre_order[k*IDX_W +: IDX_W] <= pre_used[k] ? IDX_W'(pre_loc[k]) : SLOT_EMPTY;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_TILES; i++) begin
      tile_x[i*COORD_W +: COORD_W] = pos_x[i];
      tile_y[i*COORD_W +: COORD_W] = pos_y[i];
    end
  end

  assign tile_placed  = placed;
  assign morph_dilate = dil;
endmodule

// File: rtl/tile_arranger_chk.sv
module tile_arranger_chk
  import tile_arr_pkg::*;
#(
  parameter int SCR_W     = 640,
  parameter int SCR_H     = 480,
  parameter int TILE_W    = 64,
  parameter int TILE_H    = 32,
  parameter int REL_TH    = 2_000_000,
  parameter int PRE_Y     = 120,
  parameter int PRE_H     = 60,
  parameter int MOR_Y     = 120,
  parameter int MOR_H     = 60,
  parameter int HOME_X0   = 40,
  parameter int HOME_STEP = 80,
  parameter int HOME_Y    = 300
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         btn_level,
  input logic                         btn_press,
  input logic                         drag_on,
  input logic [IDX_W-1:0]             drag_sel,
  input logic [NUM_TILES*COORD_W-1:0] tile_x,
  input logic [NUM_TILES*COORD_W-1:0] tile_y,
  input logic [NUM_TILES-1:0]         tile_placed,
  input logic [NUM_MOR-1:0]           morph_dilate
);
  localparam int LR_W = $clog2(REL_TH + 2);

  // consecutive low samples of the button, saturating
  logic [LR_W-1:0] low_run;
  always_ff @(posedge clk) begin
    if (rst || btn_level)             low_run <= '0;
    else if (low_run != LR_W'(REL_TH)) low_run <= low_run + 1'b1;
  end

  // R2: a drag begins only on a press edge
  assert_drag_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(drag_on) |-> $past(btn_press));

  // R4: a drag ends only after the full low run
  assert_release_run_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(drag_on) |-> (low_run >= LR_W'(REL_TH)));

  // R8: mode flags do not move while dragging
  assert_scroll_idle_R8: assert property (@(posedge clk) disable iff (rst)
    drag_on |=> $stable(morph_dilate));

  for (genvar i = 0; i < NUM_TILES; i++) begin : g_tile
    localparam int SNAP_Y = (i < NUM_PRE) ? PRE_Y + (PRE_H - TILE_H) / 2
                                          : MOR_Y + (MOR_H - TILE_H) / 2;

    // R3: tiles never leave the screen
    assert_on_screen_R3: assert property (@(posedge clk) disable iff (rst)
      (int'(tile_x[i*COORD_W +: COORD_W]) <= SCR_W - TILE_W) &&
      (int'(tile_y[i*COORD_W +: COORD_W]) <= SCR_H - TILE_H));

    // R5: an idle unplaced tile rests at home
    assert_rest_home_R5: assert property (@(posedge clk) disable iff (rst)
      (!tile_placed[i] && !(drag_on && drag_sel == IDX_W'(i))) |->
      ((int'(tile_x[i*COORD_W +: COORD_W]) == HOME_X0 + i * HOME_STEP) &&
       (int'(tile_y[i*COORD_W +: COORD_W]) == HOME_Y)));

    // R7: a settled placed tile is centred vertically in its zone
    assert_zone_row_R7: assert property (@(posedge clk) disable iff (rst)
      (tile_placed[i] && $past(tile_placed[i])) |->
      (int'(tile_y[i*COORD_W +: COORD_W]) == SNAP_Y));
  end
endmodule

bind tile_arranger tile_arranger_chk #(
  .SCR_W(SCR_W), .SCR_H(SCR_H), .TILE_W(TILE_W), .TILE_H(TILE_H),
  .REL_TH(REL_TH), .PRE_Y(PRE_Y), .PRE_H(PRE_H), .MOR_Y(MOR_Y), .MOR_H(MOR_H),
  .HOME_X0(HOME_X0), .HOME_STEP(HOME_STEP), .HOME_Y(HOME_Y)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .btn_level    (btn_level),
  .btn_press    (btn_press),
  .drag_on      (drag_on),
  .drag_sel     (drag_sel),
  .tile_x       (tile_x),
  .tile_y       (tile_y),
  .tile_placed  (tile_placed),
  .morph_dilate (morph_dilate)
);

// File: tb/tile_arranger_bench.sv
module tile_arranger_bench;
  localparam int TW = 64, TH = 32, RT = 6;
  localparam int PX = 40, PY = 120, PW = 200, PH = 60, PG = 16;
  localparam int MX = 280, MY = 120, MW = 320, MH = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] cur_x = '0, cur_y = '0;
  logic btn_level = 1'b0, btn_press = 1'b0, scroll_up = 1'b0, scroll_down = 1'b0;
  logic [59:0] tile_x, tile_y;
  logic [5:0]  tile_placed;
  logic [3:0]  morph_dilate, slot_dilate;
  logic [11:0] slot_order;
  logic [5:0]  pre_order;

  always #4 clk = ~clk;

  tile_arranger #(.REL_TH(RT)) u_tile_arranger (
    .clk(clk), .rst(rst), .cur_x(cur_x), .cur_y(cur_y),
    .btn_level(btn_level), .btn_press(btn_press),
    .scroll_up(scroll_up), .scroll_down(scroll_down),
    .tile_x(tile_x), .tile_y(tile_y), .tile_placed(tile_placed),
    .morph_dilate(morph_dilate), .slot_dilate(slot_dilate),
    .slot_order(slot_order), .pre_order(pre_order)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;
  int mx[6], my[6];
  bit mpl[6];
  bit mdil[4];
  int dt;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int hx(int i); return 40 + 80 * i; endfunction

  function automatic int rank_of(int base, int m, int i);
    int r = 0;
    for (int j = 0; j < m; j++)
      if (j != i && mpl[base+j] &&
          (mx[base+j] < mx[base+i] || (mx[base+j] == mx[base+i] && j < i))) r++;
    return r;
  endfunction

  task automatic resnap(input int base, input int m, input int zx, input int zy,
                        input int zw, input int zh, input int gap);
    int n = 0;
    int nx[4];
    for (int i = 0; i < m; i++) n += mpl[base+i];
    for (int i = 0; i < m; i++)
      nx[i] = zx + (zw - n * TW - (n - 1) * gap) / 2 + rank_of(base, m, i) * (TW + gap);
    for (int i = 0; i < m; i++)
      if (mpl[base+i]) begin mx[base+i] = nx[i]; my[base+i] = zy + (zh - TH) / 2; end
  endtask

  task automatic resnap_all();
    resnap(0, 2, PX, PY, PW, PH, PG);
    resnap(2, 4, MX, MY, MW, MH, 0);
  endtask

  task automatic check_state(input string req);
    int eo[4], ep[2], ed[4];
    for (int i = 0; i < 6; i++) begin
      chk(tile_x[i*10 +: 10] == mx[i], {req, " x"}, tile_x[i*10 +: 10], mx[i]);
      chk(tile_y[i*10 +: 10] == my[i], {req, " y"}, tile_y[i*10 +: 10], my[i]);
      chk(tile_placed[i] == mpl[i], {req, " placed"}, tile_placed[i], mpl[i]);
    end
    for (int k = 0; k < 4; k++) begin eo[k] = 7; ed[k] = 0; end
    for (int k = 0; k < 2; k++) ep[k] = 7;
    for (int i = 0; i < 4; i++)
      if (mpl[2+i]) begin eo[rank_of(2, 4, i)] = 2 + i; ed[rank_of(2, 4, i)] = mdil[i]; end
    for (int i = 0; i < 2; i++)
      if (mpl[i]) ep[rank_of(0, 2, i)] = i;
    for (int k = 0; k < 4; k++) begin
      chk(slot_order[k*3 +: 3] == eo[k], "R9 slot_order", slot_order[k*3 +: 3], eo[k]);
      chk(slot_dilate[k] == ed[k], "R10 slot_dilate", slot_dilate[k], ed[k]);
      chk(morph_dilate[k] == mdil[k], "R10 morph_dilate", morph_dilate[k], mdil[k]);
    end
    for (int k = 0; k < 2; k++)
      chk(pre_order[k*3 +: 3] == ep[k], "R9 pre_order", pre_order[k*3 +: 3], ep[k]);
  endtask

  task automatic pick(input int t);
    @(negedge clk);
    cur_x = 10'(mx[t] + TW / 2); cur_y = 10'(my[t] + TH / 2); btn_level = 0;
    @(negedge clk);
    btn_press = 1; btn_level = 1;
    @(negedge clk);
    btn_press = 0;
    dt = t;
    mpl[t] = 0;
    resnap_all();
  endtask

  task automatic hold_at(input int x, input int y);
    int tx, ty;
    cur_x = 10'(x); cur_y = 10'(y);
    repeat (3) @(negedge clk);
    tx = x - TW / 2; ty = y - TH / 2;
    if (tx < 0) tx = 0;
    if (tx > 640 - TW) tx = 640 - TW;
    if (ty < 0) ty = 0;
    if (ty > 480 - TH) ty = 480 - TH;
    mx[dt] = tx; my[dt] = ty;
    chk(tile_x[dt*10 +: 10] == tx, "R3 drag x", tile_x[dt*10 +: 10], tx);
    chk(tile_y[dt*10 +: 10] == ty, "R3 drag y", tile_y[dt*10 +: 10], ty);
  endtask

  task automatic release_full(input string req);
    int cx, cy;
    bit ok;
    btn_level = 0;
    repeat (RT + 4) @(negedge clk);
    cx = mx[dt] + TW / 2; cy = my[dt] + TH / 2;
    if (dt < 2) ok = (cx >= PX && cx < PX + PW && cy >= PY && cy < PY + PH);
    else        ok = (cx >= MX && cx < MX + MW && cy >= MY && cy < MY + MH);
    if (ok) mpl[dt] = 1;
    else begin mx[dt] = hx(dt); my[dt] = 300; end
    resnap_all();
    check_state(req);
  endtask

  task automatic scroll_at(input int t, input bit up, input string req);
    @(negedge clk);
    cur_x = 10'(mx[t] + TW / 2); cur_y = 10'(my[t] + TH / 2);
    @(negedge clk);
    scroll_up = up; scroll_down = !up;
    @(negedge clk);
    scroll_up = 0; scroll_down = 0;
    if (t >= 2) mdil[t-2] = !mdil[t-2];
    repeat (3) @(negedge clk);
    check_state(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 6; i++) begin mx[i] = hx(i); my[i] = 300; mpl[i] = 0; end
    for (int k = 0; k < 4; k++) mdil[k] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_state("R1 reset");

    // R2: press over empty screen does nothing
    cur_x = 620; cur_y = 20;
    @(negedge clk); btn_press = 1; btn_level = 1;
    @(negedge clk); btn_press = 0; btn_level = 0;
    repeat (RT + 3) @(negedge clk);
    check_state("R2 empty press");

    // R7 single morph tile, R6 single and paired preprocessing tiles
    pick(2); hold_at(300, 150); release_full("R7 one morph");
    pick(0); hold_at(100, 150); release_full("R6 one pre");
    pick(1); hold_at(200, 150); release_full("R6 pre pair");
    // R9 ordering by drop position
    pick(4); hold_at(290, 150); release_full("R9 insert left");
    pick(3); hold_at(595, 170); release_full("R7 three morph");
    // R5 wrong zone
    pick(5); hold_at(150, 150); release_full("R5 wrong zone");
    // R2 re-pick a placed tile clears its flag, R6 re-centres remaining one
    pick(0); hold_at(400, 420);
    repeat (3) @(negedge clk);
    check_state("R2 lift placed");
    release_full("R5 outside");

    // R3 clamping and R4 short low run
    pick(5);
    hold_at(2, 470);
    hold_at(639, 0);
    btn_level = 0;
    repeat (RT - 1) @(negedge clk);
    btn_level = 1;
    hold_at(100, 420);   // still dragging: R4
    chk(tile_placed[5] == 0, "R4 still dragging", tile_placed[5], 0);
    release_full("R5 home after clamp");

    // R8 scroll toggles
    scroll_at(2, 1, "R8 toggle placed");
    scroll_at(5, 0, "R8 toggle home");
    mdil[0] = mdil[0];
    // scroll over preprocessing tile: no change
    scroll_at(1, 1, "R8 pre ignored");
    // scroll during drag: no change
    pick(4);
    hold_at(mx[4] + TW / 2 + 1, my[4] + TH / 2);
    scroll_up = 1; @(negedge clk); scroll_up = 0;
    repeat (2) @(negedge clk);
    chk(morph_dilate[2] == mdil[2], "R8 drag ignored", morph_dilate[2], mdil[2]);
    hold_at(450, 150);
    release_full("R7 re-drop");

    // constrained random drops
    for (int it = 0; it < 40; it++) begin
      int t, mode, x, y;
      t = int'($urandom % 6);
      mode = int'($urandom % 3);
      if (mode == 0) begin
        if (t < 2) begin x = PX + int'($urandom % PW); y = PY + int'($urandom % PH); end
        else       begin x = MX + int'($urandom % MW); y = MY + int'($urandom % MH); end
      end else if (mode == 1) begin
        if (t < 2) begin x = MX + int'($urandom % MW); y = MY + int'($urandom % MH); end
        else       begin x = PX + int'($urandom % PW); y = PY + int'($urandom % PH); end
      end else begin
        x = int'($urandom % 640); y = int'($urandom % 480);
      end
      pick(t);
      hold_at(x, y);
      release_full("R5 R6 R7 random");
      if (it % 4 == 3) scroll_at(2 + int'($urandom % 4), 1'($urandom % 2), "R8 R10 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule